// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block holds a wall-clock calendar (seconds, minutes, hours, day of week, day of month, month, year). It moves that calendar forward by one second each time a 1 Hz tick arrives. Each advance runs as an update window. The busy flag goes high at once and stays high for a fixed, parameterized number of reference cycles. During that time software reads the old values. When the window closes, every field is rewritten in one cycle and a one-cycle done pulse goes to the interrupt logic.

Software reaches the fields through a small indexed register port. Three control inputs govern the engine: a hold bit that freezes the calendar while it is being loaded, a format bit that selects packed BCD or plain binary, and a clock-style bit that selects 24-hour or 12-hour hours. The block reads the format and clock-style bits live. Each update decodes the stored fields under the current settings and re-encodes them under the same settings. Stored values are not converted when a setting changes.

Top module: `cal_update_engine`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, while day of week, day of month and month read 0x01; busy and done are both low.
- R2: The fields live at bus indices 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year. A write to a field index takes effect at the next clock edge. Any other index reads 0x00, and a write to it changes no field.
- R3: A tick seen while hold is low and no window is open raises busy on the next cycle. Busy then stays high for exactly LEAD_CYC+UPD_CYC cycles. All fields change on the edge where busy falls, and a read during the window returns the values from before the update.
- R4: Done is high for exactly one cycle, the first cycle after busy falls at the end of a completed window.
- R5: While hold is high, ticks start no window. Raising hold during a window ends the window on the next edge, with no field change and no done pulse.
- R6: A tick that arrives while a window is open is dropped. It neither lengthens the window nor queues a further update.
- R7: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours.
- R8: In 24-hour mode (clock-style bit 1) hours roll from 23 to 0. That roll advances day of month and advances day of week, which runs 1 to 7 and wraps from 7 to 1.
- R9: In 12-hour mode (clock-style bit 0) hours hold 1 to 12 in bits 6:0 and bit 7 is 1 for PM. 11 AM steps to 12 PM, 12 PM steps to 1 PM, and 11 PM steps to 12 AM with a day carry (BCD: 0x11→0x92, 0x92→0x81, 0x91→0x12).
- R10: With the format bit 0, every field counts in packed BCD (seconds 0x09 steps to 0x10). With the format bit 1, every field counts in plain binary (seconds 0x09 steps to 0x0A).
- R11: Day of month wraps to 1 after 31 in January, March, May, July, August, October and December, and after 30 in April, June, September and November. February wraps after 29 when the year is a multiple of 4 and after 28 otherwise. Each wrap advances the month.
- R12: Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 0.
- R13: A field write while hold is low, whether outside or inside a window, is kept, and the next completed update counts on from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_we | input | 1 | Field write strobe |
| bus_addr | input | 4 | Field index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ctl_set | input | 1 | Hold: freezes the calendar for loading |
| ctl_binary | input | 1 | 1 = binary fields, 0 = packed BCD |
| ctl_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit |
| upd_busy | output | 1 | Update window open; fields not yet rewritten |
| upd_done | output | 1 | One-cycle pulse after a completed update |

## Verification
The carry chain is driven from several starting times. A plain mid-minute second shows that only one field moves. Values of 59, 23:59:59, month ends and December 31 of year 99 each reach one step further along the chain, and together they separate a carry that stops too early from one that runs too far. The same seconds, hours and month-end values are tried in both BCD and binary and in both hour styles, which exposes any digit-adjust or PM-bit fault. The window itself is driven with stray ticks, a mid-window write and a mid-window hold, which separate dropping a tick, reusing a written value and aborting without commit.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned FLD_W  = 8;
    localparam int unsigned IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_SEC  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_MIN  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_HOUR = 4'd4;
    localparam logic [IDX_W-1:0] IDX_DOW  = 4'd6;
    localparam logic [IDX_W-1:0] IDX_DOM  = 4'd7;
    localparam logic [IDX_W-1:0] IDX_MON  = 4'd8;
    localparam logic [IDX_W-1:0] IDX_YEAR = 4'd9;

    typedef struct packed {
        logic [FLD_W-1:0] sec;
        logic [FLD_W-1:0] min;
        logic [FLD_W-1:0] hour;
        logic [FLD_W-1:0] dow;
        logic [FLD_W-1:0] dom;
        logic [FLD_W-1:0] mon;
        logic [FLD_W-1:0] year;
    } cal_time_t;

    typedef enum logic {SQ_IDLE, SQ_WIN} seq_state_e;

    // Stored field (BCD or binary) to a plain count value.
    function automatic logic [6:0] fld_to_bin(input logic [7:0] v, input logic bin_mode);
        if (bin_mode) return v[6:0];
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Plain count value to the stored encoding.
    function automatic logic [7:0] fld_from_bin(input logic [6:0] b, input logic bin_mode);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = b / 7'd10;
        ones = b % 7'd10;
        if (bin_mode) return {1'b0, b};
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

    // Stored hours to 0..23.
    function automatic logic [6:0] hour_to_24(input logic [7:0] raw, input logic h24, input logic bin_mode);
        logic [6:0] hb;
        logic [6:0] base;
        hb = fld_to_bin({1'b0, raw[6:0]}, bin_mode);
        if (h24) return hb;
        base = (hb == 7'd12) ? 7'd0 : hb;
        return raw[7] ? base + 7'd12 : base;
    endfunction

    // 0..23 to stored hours.
    function automatic logic [7:0] hour_from_24(input logic [6:0] h, input logic h24, input logic bin_mode);
        logic       pm;
        logic [6:0] h12;
        logic [7:0] enc;
        if (h24) return fld_from_bin(h, bin_mode);
        pm  = (h >= 7'd12);
        h12 = pm ? h - 7'd12 : h;
        if (h12 == 7'd0) h12 = 7'd12;
        enc = fld_from_bin(h12, bin_mode);
        return {pm, enc[6:0]};
    endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq
    import cal_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 4,
    parameter int unsigned UPD_CYC  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    output logic busy,
    output logic commit,
    output logic done
);
    localparam int unsigned TOTAL = LEAD_CYC + UPD_CYC;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    assign busy   = (state_q == SQ_WIN);
    assign commit = busy && !hold && (cnt_q == CW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= commit;
            case (state_q)
                SQ_IDLE: begin
                    if (tick && !hold) begin
                        state_q <= SQ_WIN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (hold || commit) state_q <= SQ_IDLE;
                    else                cnt_q   <= cnt_q + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cal_next.sv
module cal_next
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      bin_mode,
    input  logic      h24,
    output cal_time_t nxt
);
    logic [6:0] s, mi, h, dw, dm, mo, yr;
    logic [6:0] s_n, mi_n, h_n, dw_n, dm_n, mo_n, yr_n;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s  = fld_to_bin(cur.sec, bin_mode);
        mi = fld_to_bin(cur.min, bin_mode);
        h  = hour_to_24(cur.hour, h24, bin_mode);
        dw = fld_to_bin(cur.dow, bin_mode);
        dm = fld_to_bin(cur.dom, bin_mode);
        mo = fld_to_bin(cur.mon, bin_mode);
        yr = fld_to_bin(cur.year, bin_mode);

        c_min = (s >= 7'd59);
        s_n   = c_min ? 7'd0 : s + 7'd1;

        c_hr  = c_min && (mi >= 7'd59);
        mi_n  = c_min ? ((mi >= 7'd59) ? 7'd0 : mi + 7'd1) : mi;

        c_day = c_hr && (h >= 7'd23);
        h_n   = c_hr ? ((h >= 7'd23) ? 7'd0 : h + 7'd1) : h;

        dw_n  = c_day ? ((dw >= 7'd7) ? 7'd1 : dw + 7'd1) : dw;

        c_mon = c_day && (dm >= month_days(mo, yr));
        dm_n  = c_day ? (c_mon ? 7'd1 : dm + 7'd1) : dm;

        c_yr  = c_mon && (mo >= 7'd12);
        mo_n  = c_mon ? (c_yr ? 7'd1 : mo + 7'd1) : mo;

        yr_n  = c_yr ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;

        nxt.sec  = fld_from_bin(s_n, bin_mode);
        nxt.min  = fld_from_bin(mi_n, bin_mode);
        nxt.hour = hour_from_24(h_n, h24, bin_mode);
        nxt.dow  = fld_from_bin(dw_n, bin_mode);
        nxt.dom  = fld_from_bin(dm_n, bin_mode);
        nxt.mon  = fld_from_bin(mo_n, bin_mode);
        nxt.year = fld_from_bin(yr_n, bin_mode);
    end
endmodule

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [FLD_W-1:0] wdata,
    input  logic             commit,
    input  cal_time_t        nxt,
    output cal_time_t        cur,
    output logic [FLD_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                     dom: 8'h01, mon: 8'h01, year: 8'h00};
        end else begin
            if (commit) cur <= nxt;
            // A bus write to a field wins over the commit for that field.
            if (we) begin
                case (addr)
                    IDX_SEC:  cur.sec  <= wdata;
                    IDX_MIN:  cur.min  <= wdata;
                    IDX_HOUR: cur.hour <= wdata;
                    IDX_DOW:  cur.dow  <= wdata;
                    IDX_DOM:  cur.dom  <= wdata;
                    IDX_MON:  cur.mon  <= wdata;
                    IDX_YEAR: cur.year <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            IDX_SEC:  rdata = cur.sec;
            IDX_MIN:  rdata = cur.min;
            IDX_HOUR: rdata = cur.hour;
            IDX_DOW:  rdata = cur.dow;
            IDX_DOM:  rdata = cur.dom;
            IDX_MON:  rdata = cur.mon;
            IDX_YEAR: rdata = cur.year;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_update_engine.sv
module cal_update_engine
    import cal_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 4,
    parameter int unsigned UPD_CYC  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ctl_set,
    input  logic       ctl_binary,
    input  logic       ctl_24h,
    output logic       upd_busy,
    output logic       upd_done
);
    cal_time_t cur_time;
    cal_time_t nxt_time;
    logic      commit;

    cal_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .hold   (ctl_set),
        .busy   (upd_busy),
        .commit (commit),
        .done   (upd_done)
    );

    cal_next u_next (
        .cur      (cur_time),
        .bin_mode (ctl_binary),
        .h24      (ctl_24h),
        .nxt      (nxt_time)
    );

    cal_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .commit (commit),
        .nxt    (nxt_time),
        .cur    (cur_time),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/cal_update_engine_chk.sv
module cal_update_engine_chk #(
    parameter int unsigned TOTAL = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       set,
    input logic       busy,
    input logic       done,
    input logic       we,
    input logic [7:0] sec
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(tick) && !$past(set)));

    p_window_len_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < TOTAL));

    p_fields_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !we) |=> (!busy || $stable(sec)));

    p_done_after_window_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (set && !busy) |=> !busy);

    p_hold_aborts_r5: assert property (@(posedge clk) disable iff (rst)
        (set && busy) |=> (!busy && !done));

    p_no_extend_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !set && run_q == TOTAL - 1) |=> (!busy && done));
endmodule

bind cal_update_engine cal_update_engine_chk #(.TOTAL(LEAD_CYC + UPD_CYC)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_1hz),
    .set  (ctl_set),
    .busy (upd_busy),
    .done (upd_done),
    .we   (bus_we),
    .sec  (cur_time.sec)
);

// File: tb/cal_update_engine_bench.sv
module cal_update_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEAD  = 4;
    localparam int UPD   = 6;
    localparam int TOTAL = LEAD + UPD;

    localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd2, A_HOUR = 4'd4, A_DOW = 4'd6,
                           A_DOM = 4'd7, A_MON = 4'd8, A_YEAR = 4'd9;

    logic       clk = 1'b0;
    logic       rst, tick, bus_we, ctl_set, ctl_binary, ctl_24h;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       upd_busy, upd_done;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_update_engine #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) u_cal_update_engine (
        .clk(clk), .rst(rst), .tick_1hz(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_set(ctl_set),
        .ctl_binary(ctl_binary), .ctl_24h(ctl_24h), .upd_busy(upd_busy), .upd_done(upd_done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                        input logic [7:0] dw, input logic [7:0] dm, input logic [7:0] mo,
                        input logic [7:0] yr);
        ctl_set = 1'b1;
        wr(A_SEC, s); wr(A_MIN, m); wr(A_HOUR, h);
        wr(A_DOW, dw); wr(A_DOM, dm); wr(A_MON, mo); wr(A_YEAR, yr);
        @(negedge clk);
        ctl_set = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [7:0] h, input logic [7:0] m,
                              input logic [7:0] s, input logic [7:0] dw, input logic [7:0] dm,
                              input logic [7:0] mo, input logic [7:0] yr);
        rd_chk({tag, " sec"}, A_SEC, s);
        rd_chk({tag, " min"}, A_MIN, m);
        rd_chk({tag, " hour"}, A_HOUR, h);
        rd_chk({tag, " dow"}, A_DOW, dw);
        rd_chk({tag, " dom"}, A_DOM, dm);
        rd_chk({tag, " mon"}, A_MON, mo);
        rd_chk({tag, " year"}, A_YEAR, yr);
    endtask

    // act: 0 plain, 1 stray tick mid-window, 2 seconds write mid-window
    task automatic run_second(input string tag, input int act, input logic [7:0] old_sec,
                              input logic [7:0] mid_val);
        bit bad;
        bad = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        #1 chk({tag, " R3 busy rises"}, 8'(upd_busy), 8'h01);
        for (int i = 1; i < TOTAL; i++) begin
            @(negedge clk);
            if (i == 1) begin
                bus_addr = A_SEC;
                #1 chk({tag, " R3 old seconds during window"}, bus_rdata, old_sec);
            end
            if (i == 2) begin
                if (act == 1) tick = 1'b1;
                if (act == 2) begin bus_we = 1'b1; bus_addr = A_SEC; bus_wdata = mid_val; end
            end
            if (i == 3) begin tick = 1'b0; bus_we = 1'b0; end
            #1 if (upd_busy !== 1'b1 || upd_done !== 1'b0) bad = 1'b1;
        end
        chk({tag, " R3 busy held for whole window"}, 8'(bad), 8'h00);
        @(negedge clk);
        #1 chk({tag, " R3 busy falls"}, 8'(upd_busy), 8'h00);
        chk({tag, " R4 done pulse"}, 8'(upd_done), 8'h01);
        @(negedge clk);
        #1 chk({tag, " R4 done one cycle"}, 8'(upd_done), 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", 8'(upd_busy), 8'h00);
        chk("R1 done after reset", 8'(upd_done), 8'h00);
        expect_all("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_map();
        load(8'h13, 8'h24, 8'h35, 8'h04, 8'h17, 8'h08, 8'h42);
        expect_all("R2 map", 8'h13, 8'h24, 8'h35, 8'h04, 8'h17, 8'h08, 8'h42);
        ctl_set = 1'b1;
        wr(4'd1, 8'hAA); wr(4'd3, 8'hBB); wr(4'd10, 8'hCC); wr(4'd15, 8'hDD);
        ctl_set = 1'b0;
        rd_chk("R2 unused index 1 reads 0", 4'd1, 8'h00);
        rd_chk("R2 unused index 10 reads 0", 4'd10, 8'h00);
        expect_all("R2 unused writes", 8'h13, 8'h24, 8'h35, 8'h04, 8'h17, 8'h08, 8'h42);
    endtask

    task automatic t_window();
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h10, 8'h20, 8'h05, 8'h02, 8'h03, 8'h04, 8'h23);
        run_second("R3 plain", 0, 8'h05, 8'h00);
        expect_all("R3 one step", 8'h10, 8'h20, 8'h06, 8'h02, 8'h03, 8'h04, 8'h23);
        run_second("R6 stray tick", 1, 8'h06, 8'h00);
        repeat (TOTAL + 3) @(negedge clk);
        #1 chk("R6 no queued update", 8'(upd_busy), 8'h00);
        rd_chk("R6 advanced once", A_SEC, 8'h07);
    endtask

    task automatic t_hold();
        bit seen;
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h01, 8'h02, 8'h30, 8'h01, 8'h01, 8'h01, 8'h00);
        ctl_set = 1'b1;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        seen = 1'b0;
        repeat (TOTAL + 2) begin @(negedge clk); #1 if (upd_busy || upd_done) seen = 1'b1; end
        chk("R5 hold blocks tick", 8'(seen), 8'h00);
        rd_chk("R5 seconds frozen", A_SEC, 8'h30);
        ctl_set = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        #1 chk("R5 window opened", 8'(upd_busy), 8'h01);
        ctl_set = 1'b1;
        @(negedge clk);
        #1 chk("R5 hold aborts window", 8'(upd_busy), 8'h00);
        seen = 1'b0;
        repeat (TOTAL + 2) begin @(negedge clk); #1 if (upd_done) seen = 1'b1; end
        chk("R5 no done after abort", 8'(seen), 8'h00);
        rd_chk("R5 no commit after abort", A_SEC, 8'h30);
        ctl_set = 1'b0;
    endtask

    task automatic t_formats();
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h05, 8'h10, 8'h09, 8'h03, 8'h03, 8'h03, 8'h10);
        run_second("R10 bcd", 0, 8'h09, 8'h00);
        rd_chk("R10 bcd 09 to 10", A_SEC, 8'h10);
        ctl_binary = 1'b1;
        load(8'd5, 8'd10, 8'd9, 8'd3, 8'd3, 8'd3, 8'd10);
        run_second("R10 bin", 0, 8'd9, 8'h00);
        rd_chk("R10 binary 9 to 10", A_SEC, 8'h0A);
        load(8'd5, 8'd10, 8'd59, 8'd3, 8'd3, 8'd3, 8'd10);
        run_second("R7 bin", 0, 8'd59, 8'h00);
        expect_all("R7 binary seconds carry", 8'd5, 8'd11, 8'd0, 8'd3, 8'd3, 8'd3, 8'd10);
        ctl_binary = 1'b0;
    endtask

    task automatic t_carry();
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h08, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h30);
        run_second("R7", 0, 8'h59, 8'h00);
        expect_all("R7 minute carry", 8'h09, 8'h00, 8'h00, 8'h02, 8'h10, 8'h05, 8'h30);
        load(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h06, 8'h21);
        run_second("R8", 0, 8'h59, 8'h00);
        expect_all("R8 day carry dow wrap", 8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h06, 8'h21);
    endtask

    task automatic t_12h();
        ctl_binary = 1'b0; ctl_24h = 1'b0;
        load(8'h11, 8'h59, 8'h59, 8'h03, 8'h10, 8'h02, 8'h22);
        run_second("R9 am", 0, 8'h59, 8'h00);
        rd_chk("R9 11AM to 12PM", A_HOUR, 8'h92);
        load(8'h92, 8'h59, 8'h59, 8'h03, 8'h10, 8'h02, 8'h22);
        run_second("R9 noon", 0, 8'h59, 8'h00);
        rd_chk("R9 12PM to 1PM", A_HOUR, 8'h81);
        load(8'h91, 8'h59, 8'h59, 8'h03, 8'h10, 8'h02, 8'h22);
        run_second("R9 pm", 0, 8'h59, 8'h00);
        expect_all("R9 11PM to 12AM", 8'h12, 8'h00, 8'h00, 8'h04, 8'h11, 8'h02, 8'h22);
        ctl_24h = 1'b1;
    endtask

    task automatic t_month();
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
        run_second("R11 feb", 0, 8'h59, 8'h00);
        expect_all("R11 feb 28 common year", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23);
        load(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
        run_second("R11 leap", 0, 8'h59, 8'h00);
        rd_chk("R11 leap feb 29 dom", A_DOM, 8'h29);
        rd_chk("R11 leap feb 29 mon", A_MON, 8'h02);
        load(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h23);
        run_second("R11 apr", 0, 8'h59, 8'h00);
        rd_chk("R11 apr 30 dom", A_DOM, 8'h01);
        rd_chk("R11 apr 30 mon", A_MON, 8'h05);
        load(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h23);
        run_second("R11 may", 0, 8'h59, 8'h00);
        rd_chk("R11 may 30 to 31", A_DOM, 8'h31);
        load(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        run_second("R12", 0, 8'h59, 8'h00);
        expect_all("R12 year wrap", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);
        ctl_binary = 1'b1;
        load(8'd23, 8'd59, 8'd59, 8'd1, 8'd29, 8'd2, 8'd24);
        run_second("R11 bin", 0, 8'd59, 8'h00);
        rd_chk("R11 binary leap dom", A_DOM, 8'd1);
        rd_chk("R11 binary leap mon", A_MON, 8'd3);
        ctl_binary = 1'b0;
    endtask

    task automatic t_live_write();
        ctl_binary = 1'b0; ctl_24h = 1'b1;
        load(8'h02, 8'h03, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(A_SEC, 8'h30);
        rd_chk("R13 write with hold low", A_SEC, 8'h30);
        run_second("R13 idle write", 0, 8'h30, 8'h00);
        rd_chk("R13 counts from written", A_SEC, 8'h31);
        run_second("R13 window write", 2, 8'h31, 8'h40);
        rd_chk("R13 mid-window write used", A_SEC, 8'h41);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        ctl_set = 1'b0; ctl_binary = 1'b0; ctl_24h = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_map();
        t_window();
        t_hold();
        t_formats();
        t_carry();
        t_12h();
        t_month();
        t_live_write();
        report();
        $finish;
    end
endmodule